// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block takes a two-channel, 16-bit audio stream carried on three wires (bit clock, word select and data) and turns it into parallel left/right sample pairs in the system clock domain. All three serial lines are resynchronised into the system clock, which must run at least six times faster than the bit clock. Edges are found there. The stream is right-justified: each channel's 16 valid bits, two's complement with the MSB first, are the final 16 bits shifted in before word select toggles. Any bits shifted in earlier in that half-frame are padding and are dropped. This lets the bit clock run anywhere from 32 to 64 periods per sample.

Word select high carries the left channel and low carries the right channel. A complete pair is delivered with a one-cycle strobe when word select rises, because that edge closes the right-channel word. After reset the output is held muted while the framing settles. The count of rising word-select edges starts at the first one seen after reset, whatever phase the stream was in when reset ended. Delivery begins at the ninth such edge. A zero-detect flag is raised from reset until the first high data bit arrives. It is raised again after a configurable number of sample periods in which the data line never went high.

Top module: `rj_audio_rx`

## Requirements
- R1: A data bit is taken on each rising edge of the bit clock. The word finished by a falling word-select edge is the left sample, and the word finished by a rising edge is the right sample. In each sample the earliest of the 16 bits is bit 15 (the MSB).
- R2: Only the last 16 bits before a word-select edge form the sample. Bits shifted in earlier in a half-frame of 16 to 32 bit periods have no effect on the delivered values.
- R3: On each rising word-select edge after release, `out_valid` is high for exactly one system cycle, and at that moment `out_left`/`out_right` show the pair just completed. When `out_valid` is low, both sample outputs hold their values.
- R4: Reset drives `muted` high, `out_valid` low and both sample outputs to zero. No pair is delivered until the ninth rising word-select edge after reset. On that edge `muted` falls in the same cycle as the first `out_valid`, and `muted` stays low until the next reset.
- R5: Counting of rising word-select edges begins at the first rising edge after reset, even when reset ends partway through a half-frame. The level word select has during reset is not counted as an edge.
- R6: `zero_flag` is high from reset until a high data bit is sampled.
- R7: Any high data bit sampled on a bit-clock rising edge clears `zero_flag` within four system cycles, without waiting for a word-select edge.
- R8: `zero_flag` goes high on the ZERO_FRAMES-th rising word-select edge with no high data bit sampled since the last high bit. It stays low before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 6x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial bit clock (asynchronous) |
| ws | input | 1 | Word select; high = left, low = right (asynchronous) |
| sd | input | 1 | Serial data, MSB first (asynchronous) |
| out_left | output | 16 | Left sample of the last delivered pair |
| out_right | output | 16 | Right sample of the last delivered pair |
| out_valid | output | 1 | One-cycle strobe marking a new pair |
| muted | output | 1 | High while output is held after reset |
| zero_flag | output | 1 | High when no nonzero data has arrived for a long run |

## Verification
Two functions can act in the same cycle, and both are triggered by the same rising word-select edge. That edge can deliver a pair with `out_valid`, and it can also be the one that completes the run of silent sample periods and raises `zero_flag`. The bench provokes this by sending a frame whose right word holds a high bit, then zero frames until the run length is reached. It checks that the flag is still low one edge before the limit and high right after it. In the same window the scoreboard confirms that the all-zero pair closed by that edge is still delivered unchanged. Release at the ninth edge is the second coincidence: the first strobe and the fall of `muted` are checked against the same frame, both after a clean start and after a reset taken in the middle of a half-frame.

// File: rtl/rj_audio_rx.sv
module rj_audio_rx #(
  parameter int SAMPLE_W      = 16,
  parameter int RELEASE_RISES = 9,
  parameter int ZERO_FRAMES   = 16384,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                ws,
  input  logic                sd,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                out_valid,
  output logic                muted,
  output logic                zero_flag
);
  localparam int REL_W = $clog2(RELEASE_RISES + 1);
  localparam int ZC_W  = $clog2(ZERO_FRAMES + 1);
  localparam logic [REL_W-1:0] REL_MAX  = REL_W'(RELEASE_RISES);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_RISES - 1);
  localparam logic [ZC_W-1:0]  Z_MAX    = ZC_W'(ZERO_FRAMES);
  localparam logic [ZC_W-1:0]  Z_LAST   = ZC_W'(ZERO_FRAMES - 1);

  logic [SYNC_STAGES:0]   sck_p, ws_p, fill;
  logic [SYNC_STAGES-1:0] sd_p;
  logic [SAMPLE_W-1:0]    shreg, left_q;
  logic [REL_W-1:0]       rise_cnt;
  logic [ZC_W-1:0]        zcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      ws_p  <= '0;
      sd_p  <= '0;
      fill  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], sck};
      ws_p  <= {ws_p[SYNC_STAGES-1:0], ws};
      sd_p  <= {sd_p[SYNC_STAGES-2:0], sd};
      fill  <= {fill[SYNC_STAGES-1:0], 1'b1};
    end

  wire armed       = fill[SYNC_STAGES];
  wire sck_rise    = armed &  sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  wire ws_rise     = armed &  ws_p[SYNC_STAGES-1]  & ~ws_p[SYNC_STAGES];
  wire ws_fall     = armed & ~ws_p[SYNC_STAGES-1]  &  ws_p[SYNC_STAGES];
  wire sd_s        = sd_p[SYNC_STAGES-1];
  wire one_bit     = sck_rise & sd_s;
  wire release_now = ws_rise & (rise_cnt >= REL_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      left_q <= '0;
    end else begin
      if (sck_rise) shreg  <= {shreg[SAMPLE_W-2:0], sd_s};
      if (ws_fall)  left_q <= shreg;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_cnt  <= '0;
      muted     <= 1'b1;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= release_now;
      if (ws_rise && rise_cnt != REL_MAX) rise_cnt <= rise_cnt + 1'b1;
      if (release_now) begin
        muted     <= 1'b0;
        out_left  <= left_q;
        out_right <= shreg;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zcnt      <= '0;
      zero_flag <= 1'b1;
    end else if (one_bit) begin
      zcnt      <= '0;
      zero_flag <= 1'b0;
    end else if (ws_rise && zcnt != Z_MAX) begin
      zcnt <= zcnt + 1'b1;
      if (zcnt == Z_LAST) zero_flag <= 1'b1;
    end
endmodule

module rj_audio_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right,
  input logic                out_valid,
  input logic                muted
);
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_hold_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_left));

  p_hold_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_right));

  p_no_valid_muted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> !out_valid);

  p_release_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(muted) |-> out_valid);

  p_mute_stays_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !muted |=> !muted);
endmodule

bind rj_audio_rx rj_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_left(out_left), .out_right(out_right),
  .out_valid(out_valid), .muted(muted)
);

// File: tb/test_rj_audio_rx.sv
module test_rj_audio_rx;
  localparam int ZF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b1, sd = 1'b0;
  logic [15:0] out_left, out_right;
  logic out_valid, muted, zero_flag;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_l[$], exp_r[$];
  string exp_tag[$];

  always #5 clk = ~clk;

  rj_audio_rx #(.ZERO_FRAMES(ZF)) i_rj_audio_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
    .muted(muted), .zero_flag(zero_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && out_valid && !done) begin
    if (exp_l.size() == 0) begin
      checks++; fails++;
      $display("FAIL R4 unexpected pair: actual %h/%h expected none", out_left, out_right);
    end else begin
      string t = exp_tag.pop_front();
      chk({t, " left"}, out_left, exp_l.pop_front());
      chk({t, " right"}, out_right, exp_r.pop_front());
    end
  end

  task automatic send_bit(input logic w, input logic b);
    sck = 1'b0; ws = w; sd = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic w, input int nbits, input logic [15:0] v, input logic pad);
    for (int i = 0; i < nbits; i++)
      if (i < nbits - 16) send_bit(w, pad);
      else send_bit(w, v[15 - (i - (nbits - 16))]);
  endtask

  task automatic close_frame();
    sck = 1'b0; ws = 1'b1; sd = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_frame(input int nbits, input logic [15:0] l, input logic [15:0] r,
                            input logic pad, input bit push, input string tag);
    if (push) begin exp_l.push_back(l); exp_r.push_back(r); exp_tag.push_back(tag); end
    send_half(1'b1, nbits, l, pad);
    send_half(1'b0, nbits, r, pad);
    close_frame();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R4 reset muted", 16'(muted), 16'd1);
    chk("R4 reset valid", 16'(out_valid), 16'd0);
    chk("R4 reset left", out_left, 16'h0000);
    chk("R6 reset zero flag", 16'(zero_flag), 16'd1);

    for (int k = 1; k <= 8; k++) send_frame(16, 16'h0000, 16'h0000, 1'b0, 0, "");
    chk("R4 muted before ninth edge", 16'(muted), 16'd1);
    chk("R6 flag holds with silent input", 16'(zero_flag), 16'd1);

    send_frame(16, 16'hA5A5, 16'h0F0F, 1'b0, 1, "R4 first pair R1");
    chk("R4 released at ninth edge", 16'(muted), 16'd0);
    chk("R6 flag drops on data", 16'(zero_flag), 16'd0);

    send_frame(16, 16'h8000, 16'h7FFF, 1'b0, 1, "R1 extremes");
    send_frame(32, 16'h1234, 16'hFEDC, 1'b1, 1, "R2 64fs ones padding");
    send_frame(24, 16'h0001, 16'hFFFF, 1'b1, 1, "R2 48fs padding");
    send_frame(32, 16'h0000, 16'h5A5A, 1'b0, 1, "R3 64fs");
    send_frame(16, 16'hC3C3, 16'h3C3C, 1'b0, 1, "R1 32fs");

    send_frame(16, 16'h0000, 16'h0100, 1'b0, 1, "R3 run start");
    send_frame(16, 16'h0000, 16'h0000, 1'b0, 1, "R8 zero pair");
    send_frame(16, 16'h0000, 16'h0000, 1'b0, 1, "R8 zero pair");
    chk("R8 flag low one edge before limit", 16'(zero_flag), 16'd0);
    send_frame(16, 16'h0000, 16'h0000, 1'b0, 1, "R8 zero pair at limit");
    chk("R8 flag high at limit", 16'(zero_flag), 16'd1);

    exp_l.push_back(16'h0100); exp_r.push_back(16'h0000); exp_tag.push_back("R7 pair");
    send_half(1'b1, 16, 16'h0100, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 flag drops before word edge", 16'(zero_flag), 16'd0);
    send_half(1'b0, 16, 16'h0000, 1'b0);
    close_frame();

    ws = 1'b0; sck = 1'b0; sd = 1'b1;
    do_reset();
    chk("R4 muted after second reset", 16'(muted), 16'd1);
    chk("R4 left cleared by reset", out_left, 16'h0000);
    chk("R6 flag set by reset", 16'(zero_flag), 16'd1);
    send_half(1'b0, 10, 16'h0000, 1'b0);
    close_frame();
    for (int k = 2; k <= 8; k++) send_frame(16, 16'h1111, 16'h2222, 1'b0, 0, "");
    chk("R5 muted after eight edges", 16'(muted), 16'd1);
    send_frame(16, 16'h4321, 16'h8765, 1'b0, 1, "R5 first pair after resync");
    chk("R5 released at ninth edge", 16'(muted), 16'd0);

    repeat (10) @(negedge clk);
    chk("R3 scoreboard drained", 16'(exp_l.size()), 16'd0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule